// File: doc/BRIEF.md
# Display Common-Row Scan Sequencer with Partial Window

This block steps through the 67 common-row slots of a dot-matrix display, one slot per row step pulse, and reports for each physical row where its pixels live in display memory. Memory is organised as 17 banks selected by a 5-bit bank number (values 0 to 16 used directly). Each group of 8 logical rows is held in an even/odd bank pair, one bank per grey-scale plane. The block reports the even bank of the pair and the line within it. The last group, bank 16, covers only logical rows 64 to 66.

A mirror setting reverses the vertical order: physical row r reads logical row 66 - r. A partial setting restricts the visible image to 8 rows. The window either shows the bank pair 0/1 (the first 8 logical rows) or the pair 14/15 (logical rows 56 to 63). The scan still walks all 67 slots so that frame timing does not change. Rows outside the window report row-active low. While the window is in force, a flag tells the timing logic that frame-rate calibration must not run.

Mirror and partial settings are sampled only on the start-of-frame strobe. Changes between strobes wait for the next frame.

Top module: `lcd_row_scan`

## Requirements
- R1: After reset the row index is 0, the settings are normal order and full screen, row_active_o is 1, cal_block_o is 0, and bank_o and line_o are 0.
- R2: A frame_start_i pulse sets the row index to 0 at the next clock edge and latches mirror_i and part_sel_i. It takes priority over a simultaneous row_step_i.
- R3: Each row_step_i pulse without frame_start_i advances the row index by one. From 66 it wraps to 0. Without a pulse the index holds.
- R4: With mirror off, physical row r reads logical row r. bank_o = 2*(logical/8) and line_o = logical mod 8, so logical rows 64 to 66 give bank 16.
- R5: With mirror latched on, physical row r reads logical row 66 - r, using the same bank and line rule.
- R6: part_sel_i = 3'b001 selects the first-rows window: only logical rows 0 to 7 (bank 0) are active. These are physical rows 0 to 7 without mirror, and 66 down to 59 with mirror.
- R7: part_sel_i = 3'b010 selects the last-rows window: only logical rows 56 to 63 (bank 14) are active. These are physical rows 56 to 63 without mirror, and 10 down to 3 with mirror.
- R8: Any other part_sel_i value selects full screen, in which every row slot is active.
- R9: cal_block_o is 1 exactly while a partial window setting is latched.
- R10: Changes on mirror_i and part_sel_i without a frame_start_i pulse do not change the row mapping, row_active_o or cal_block_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_step_i | input | 1 | Advance to the next row slot |
| frame_start_i | input | 1 | Restart the scan at row 0 and latch the settings |
| mirror_i | input | 1 | Vertical mirror request |
| part_sel_i | input | 3 | Partial window request (001 first rows, 010 last rows, else full) |
| row_o | output | 7 | Current physical row index |
| bank_o | output | 5 | Even bank of the memory pair for this row |
| line_o | output | 3 | Line within the bank |
| row_active_o | output | 1 | Row is driven with data this frame |
| cal_block_o | output | 1 | Frame-rate calibration inhibited |

## Verification
The hardest case to reach is the mirrored partial window. It needs a latched mirror, a latched window choice and a walk across the slot where the window edge falls, which is row 59 or row 3, far from the scan start. The stimulus latches each of the four window/mirror combinations with a strobe and steps a full 67-slot frame, so that every edge is crossed. It also changes the setting inputs in the middle of a frame, without a strobe, to show that the window does not move.

// File: rtl/lcd_row_scan_pkg.sv
package lcd_row_scan_pkg;
  typedef enum logic [1:0] {MODE_FULL, MODE_FIRST, MODE_LAST} scan_mode_e;

  localparam logic [2:0] SEL_FIRST = 3'b001;
  localparam logic [2:0] SEL_LAST  = 3'b010;

  function automatic scan_mode_e decode_sel(input logic [2:0] sel);
    case (sel)
      SEL_FIRST: decode_sel = MODE_FIRST;
      SEL_LAST:  decode_sel = MODE_LAST;
      default:   decode_sel = MODE_FULL;
    endcase
  endfunction
endpackage

// File: rtl/rsc_row_counter.sv
module rsc_row_counter #(
  parameter int N_ROWS = 67,
  localparam int RW = $clog2(N_ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  output logic [RW-1:0] row_o
);
  localparam logic [RW-1:0] LAST = RW'(N_ROWS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      row_o <= '0;
    else if (start_i) row_o <= '0;
    else if (step_i)  row_o <= (row_o == LAST) ? '0 : row_o + RW'(1);
  end
endmodule

// File: rtl/rsc_cfg_latch.sv
module rsc_cfg_latch
  import lcd_row_scan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       mirror_i,
  input  logic [2:0] sel_i,
  output logic       mirror_o,
  output scan_mode_e mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mirror_o <= 1'b0;
      mode_o   <= MODE_FULL;
    end else if (start_i) begin
      mirror_o <= mirror_i;
      mode_o   <= decode_sel(sel_i);
    end
  end
endmodule

// File: rtl/rsc_row_map.sv
module rsc_row_map
  import lcd_row_scan_pkg::*;
#(
  parameter int N_ROWS    = 67,
  parameter int LINES     = 8,
  parameter int WIN_ROWS  = 8,
  parameter int LAST_BASE = 56,
  localparam int RW = $clog2(N_ROWS),
  localparam int LW = $clog2(LINES),
  localparam int BW = $clog2(2 * ((N_ROWS + LINES - 1) / LINES))
) (
  input  logic [RW-1:0] row_i,
  input  logic          mirror_i,
  input  scan_mode_e    mode_i,
  output logic [BW-1:0] bank_o,
  output logic [LW-1:0] line_o,
  output logic          active_o,
  output logic          cal_block_o
);
  logic [RW-1:0] logical;
  logic [RW-1:0] grp;
  logic [RW-1:0] win_base;
  logic          in_win;

  always_comb begin
    logical  = mirror_i ? (RW'(N_ROWS - 1) - row_i) : row_i;
    grp      = logical / RW'(LINES);
    // two planes per row group: report the even bank
    bank_o   = BW'({grp, 1'b0});
    line_o   = LW'(logical % RW'(LINES));
    win_base = (mode_i == MODE_LAST) ? RW'(LAST_BASE) : '0;
    in_win   = (logical >= win_base) && (logical < win_base + RW'(WIN_ROWS));
    active_o    = (mode_i == MODE_FULL) || in_win;
    cal_block_o = (mode_i != MODE_FULL);
  end
endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
  import lcd_row_scan_pkg::*;
#(
  parameter int N_ROWS    = 67,
  parameter int LINES     = 8,
  parameter int WIN_ROWS  = 8,
  parameter int LAST_BASE = 56
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       row_step_i,
  input  logic       frame_start_i,
  input  logic       mirror_i,
  input  logic [2:0] part_sel_i,
  output logic [6:0] row_o,
  output logic [4:0] bank_o,
  output logic [2:0] line_o,
  output logic       row_active_o,
  output logic       cal_block_o
);
  localparam int RW = $clog2(N_ROWS);
  localparam int LW = $clog2(LINES);
  localparam int BW = $clog2(2 * ((N_ROWS + LINES - 1) / LINES));

  logic [RW-1:0] row_q;
  logic          mirror_q;
  scan_mode_e    mode_q;
  logic [BW-1:0] bank_w;
  logic [LW-1:0] line_w;

  rsc_row_counter #(.N_ROWS(N_ROWS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (frame_start_i),
    .step_i  (row_step_i),
    .row_o   (row_q)
  );

  rsc_cfg_latch u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (frame_start_i),
    .mirror_i (mirror_i),
    .sel_i    (part_sel_i),
    .mirror_o (mirror_q),
    .mode_o   (mode_q)
  );

  rsc_row_map #(
    .N_ROWS(N_ROWS), .LINES(LINES), .WIN_ROWS(WIN_ROWS), .LAST_BASE(LAST_BASE)
  ) u_map (
    .row_i       (row_q),
    .mirror_i    (mirror_q),
    .mode_i      (mode_q),
    .bank_o      (bank_w),
    .line_o      (line_w),
    .active_o    (row_active_o),
    .cal_block_o (cal_block_o)
  );

  assign row_o  = 7'(row_q);
  assign bank_o = 5'(bank_w);
  assign line_o = 3'(line_w);
endmodule

// File: rtl/lcd_row_scan_chk.sv
module lcd_row_scan_chk #(
  parameter int N_ROWS = 67
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       row_step_i,
  input logic       frame_start_i,
  input logic [6:0] row_o,
  input logic [4:0] bank_o,
  input logic       row_active_o,
  input logic       cal_block_o
);
  // R2
  start_clears_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> row_o == 7'd0);

  // R3
  step_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_step_i && !frame_start_i && row_o != 7'(N_ROWS - 1) |=> row_o == $past(row_o) + 7'd1);

  // R3
  step_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_step_i && !frame_start_i && row_o == 7'(N_ROWS - 1) |=> row_o == 7'd0);

  // R3
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_step_i && !frame_start_i |=> $stable(row_o));

  // R8
  full_all_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_block_o |-> row_active_o);

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(cal_block_o));

  // R6
  win_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_block_o && row_active_o |-> (bank_o == 5'd0 || bank_o == 5'd14));
endmodule

bind lcd_row_scan lcd_row_scan_chk #(.N_ROWS(N_ROWS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .row_step_i    (row_step_i),
  .frame_start_i (frame_start_i),
  .row_o         (row_o),
  .bank_o        (bank_o),
  .row_active_o  (row_active_o),
  .cal_block_o   (cal_block_o)
);

// File: tb/sim_lcd_row_scan.sv
`timescale 1ns/1ps
module sim_lcd_row_scan;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       row_step_i = 1'b0;
  logic       frame_start_i = 1'b0;
  logic       mirror_i = 1'b0;
  logic [2:0] part_sel_i = 3'b000;
  logic [6:0] row_o;
  logic [4:0] bank_o;
  logic [2:0] line_o;
  logic       row_active_o;
  logic       cal_block_o;

  always #2 clk_i = ~clk_i;

  lcd_row_scan u0 (.*);

  typedef struct {
    logic [17:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench reference state
  int  m_row = 0;
  bit  m_mir = 0;
  int  m_mode = 0; // 0 full, 1 first, 2 last

  function automatic logic [17:0] expect_vec();
    int lg, base;
    bit act;
    lg   = m_mir ? 66 - m_row : m_row;
    base = (m_mode == 2) ? 56 : 0;
    act  = (m_mode == 0) || (lg >= base && lg < base + 8);
    return {7'(m_row), 5'((lg / 8) * 2), 3'(lg % 8), act, 1'(m_mode != 0), 1'b0};
  endfunction

  function automatic logic [17:0] actual_vec();
    return {row_o, bank_o, line_o, row_active_o, cal_block_o, 1'b0};
  endfunction

  task automatic check(input logic [17:0] act, input logic [17:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got row=%0d bank=%0d line=%0d act=%0b cal=%0b, expected row=%0d bank=%0d line=%0d act=%0b cal=%0b",
               tag, act[17:11], act[10:6], act[5:3], act[2], act[1],
               exp[17:11], exp[10:6], exp[5:3], exp[2], exp[1]);
    end
  endtask

  // driver: one clock of stimulus, expected result queued for the monitor
  task automatic cyc(input bit st, input bit en, input bit mir, input logic [2:0] sel, input string tag);
    item_t it;
    @(negedge clk_i);
    frame_start_i = st;
    row_step_i    = en;
    mirror_i      = mir;
    part_sel_i    = sel;
    if (st) begin
      m_row  = 0;
      m_mir  = mir;
      m_mode = (sel == 3'b001) ? 1 : (sel == 3'b010) ? 2 : 0;
    end else if (en) begin
      m_row = (m_row == 66) ? 0 : m_row + 1;
    end
    it.exp = expect_vec();
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic frame(input bit mir, input logic [2:0] sel, input int steps, input string tag);
    cyc(1, 0, mir, sel, tag);
    for (int i = 0; i < steps; i++) cyc(0, 1, mir, sel, tag);
  endtask

  // monitor: sample just after the edge that consumed the stimulus
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(actual_vec(), it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(actual_vec(), {7'd0, 5'd0, 3'd0, 1'b1, 1'b0, 1'b0}, "R1 reset");

    frame(0, 3'b000, 70, "R3 R4 normal scan with wrap");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 3'b000, "R3 hold");
    cyc(0, 1, 0, 3'b000, "R3 step");
    cyc(1, 1, 0, 3'b000, "R2 start beats step");
    frame(1, 3'b000, 67, "R5 mirror full");
    frame(0, 3'b001, 67, "R6 R9 first window");
    frame(1, 3'b001, 67, "R6 R9 first window mirrored");
    frame(0, 3'b010, 67, "R7 R9 last window");
    frame(1, 3'b010, 67, "R7 R9 last window mirrored");
    frame(0, 3'b011, 10, "R8 sel 011 full");
    frame(1, 3'b111, 10, "R8 sel 111 full");
    frame(0, 3'b100, 10, "R8 sel 100 full");
    // R10 settings move mid-frame without a strobe
    frame(0, 3'b010, 20, "R10 setup");
    for (int i = 0; i < 50; i++) cyc(0, 1, 1, 3'b001, "R10 no strobe");
    frame(0, 3'b000, 5, "R10 back to full");
    for (int i = 0; i < 10; i++) cyc(0, 1, 1, 3'b010, "R10 no strobe full");
    cyc(0, 0, 0, 3'b000, "R3 final hold");
    @(posedge clk_i);
    #2;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule